// File: doc/BRIEF.md
# Dual Timer/Event Counter with Pulse Capture and Divider Output

The block holds two identical 8-bit up-counters and one frequency-divider output. Each counter can run in one of three counting modes. In timer mode it counts system clocks through a power-of-two prescaler. In event mode it counts edges on its own external pin. In capture mode it measures a single pulse on that pin. The pin is synchronised to the system clock before any edge is seen. When a counter passes its top value, it sets a sticky overflow flag and reloads from its preload value. The overflow of one counter, chosen by a select input, toggles the divider output.

Software drives a per-counter configuration write strobe with the mode, edge polarity, prescaler select and enable bit. The preload value is a plain input that the counter samples when it reloads. In capture mode the counter waits for the opening edge and counts while the pulse lasts. At the closing edge it clears its own enable, so the measured width stays on the count output.

Top module: `dual_timer_pfd`

## Requirements
- R1: After reset both counts are 0, both overflow flags and both enables are 0, and the divider output is 0.
- R2: The mode code is 2'b00 idle, 2'b01 event, 2'b10 timer, 2'b11 capture. In idle mode, or with the enable clear, the count does not change.
- R3: In timer mode with prescaler select p (0 to 7), the count rises by one every 2^p clocks. The first increment lands 2^p clocks after the enabling write.
- R4: In event mode, edge select 0 counts rising pin edges and 1 counts falling edges. A pin change made before clock edge k shows on the count after edge k+2.
- R5: An increment at count 255 loads the preload value and sets the overflow flag, both at the same clock edge.
- R6: The overflow flag stays set until the flag-clear input is pulsed. An overflow in the same cycle as a clear leaves the flag set.
- R7: In capture mode with edge select 0, counting starts at a falling pin edge and stops at the next rising edge. At the stopping edge the enable clears. With prescaler select 0, the count grows by exactly the pulse width in clocks, and later pin edges leave it unchanged.
- R8: In capture mode with edge select 1, counting starts at a rising edge and stops at the next falling edge, with the same width and auto-disable behaviour as R7.
- R9: An overflow inside a capture pulse sets the flag and reloads the counter, and counting goes on until the closing edge.
- R10: The divider output toggles on each overflow of the timer chosen by the select input (0 = timer 0, 1 = timer 1). Overflows of the other timer have no effect on it.
- R11: A configuration write that sets the enable while it is clear loads the preload value into the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWr | input | 2 | Per-timer configuration write strobe |
| cfgMode | input | 2x2 | Mode code written with cfgWr |
| cfgEdge | input | 2 | Edge select written with cfgWr |
| cfgPsc | input | 2x3 | Prescaler select written with cfgWr |
| cfgEn | input | 2 | Enable bit written with cfgWr |
| preload | input | 2x8 | Reload value for each counter |
| extPin | input | 2 | Asynchronous external input for each timer |
| flagClr | input | 2 | Pulse to clear the overflow flag |
| pfdSel | input | 1 | Chooses which timer overflow drives the divider |
| count | output | 2x8 | Current count of each timer |
| ovfFlag | output | 2 | Sticky overflow flag of each timer |
| tmrEn | output | 2 | Current enable of each timer |
| pfdOut | output | 1 | Divider square-wave output |

## Verification
Two events can land on the same clock edge: a software clear of the overflow flag and a new overflow. The bench restarts timer 0 from a preload of 250 at full clock rate, which puts the overflow at a known edge, and raises the clear pulse for exactly that edge. The flag must still read 1 afterwards, while a clear on a quiet cycle must drop it. Inside capture mode, an overflow and a running pulse also overlap. That case is judged from the final count after wrap-around and from the divider output having toggled.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE    = 2'b00,
    MODE_EVENT   = 2'b01,
    MODE_TIMER   = 2'b10,
    MODE_CAPTURE = 2'b11
  } tmr_mode_e;

  // Strobes from control to datapath, one set per timer
  typedef struct packed {
    logic load;     // take preload value
    logic inc;      // count one step
    logic flagClr;  // clear overflow flag
  } tmr_strobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PSC_W = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWr,
  input  logic [1:0]  cfgMode,
  input  logic        cfgEdge,
  input  logic [PSC_W-1:0] cfgPsc,
  input  logic        cfgEn,
  input  logic        pin,
  input  logic        flagClr,
  output tmr_strobe_t strobe,
  output logic        enOut
);

  localparam int PDIV_W = (1 << PSC_W) - 1;

  tmr_mode_e         modeQ;
  logic              edgeQ;
  logic [PSC_W-1:0]  pscQ;
  logic              enQ;
  logic [1:0]        syncQ;
  logic              prevQ;
  logic [PDIV_W-1:0] pscCnt;
  logic [PDIV_W-1:0] pscMask;
  logic              inPulse;

  logic rise, fall, tick, startEdge, stopEdge, evtEdge, capStop;

  // configuration register with automatic enable clear in capture mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= MODE_IDLE;
      edgeQ <= 1'b0;
      pscQ  <= '0;
      enQ   <= 1'b0;
    end else if (cfgWr) begin
      modeQ <= tmr_mode_e'(cfgMode);
      edgeQ <= cfgEdge;
      pscQ  <= cfgPsc;
      enQ   <= cfgEn;
    end else if (capStop) begin
      enQ   <= 1'b0;
    end
  end

  // two-flop synchroniser plus history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], pin};
      prevQ <= syncQ[1];
    end
  end

  assign rise = syncQ[1] & ~prevQ;
  assign fall = ~syncQ[1] & prevQ;
  assign evtEdge   = edgeQ ? fall : rise;
  assign startEdge = edgeQ ? rise : fall;
  assign stopEdge  = edgeQ ? fall : rise;

  // prescaler: restarts on every write and while disabled
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pscCnt <= '0;
    else if (!enQ || cfgWr) pscCnt <= '0;
    else                   pscCnt <= pscCnt + 1'b1;
  end

  always_comb begin
    pscMask = '0;
    for (int k = 0; k < PDIV_W; k++) pscMask[k] = (k < int'(pscQ));
  end

  assign tick = &(pscCnt | ~pscMask);

  // capture phase tracking
  assign capStop = !cfgWr && enQ && (modeQ == MODE_CAPTURE) && inPulse && stopEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inPulse <= 1'b0;
    else if (cfgWr || !enQ || modeQ != MODE_CAPTURE) inPulse <= 1'b0;
    else if (!inPulse && startEdge) inPulse <= 1'b1;
    else if (inPulse && stopEdge)   inPulse <= 1'b0;
  end

  always_comb begin
    strobe.load    = cfgWr && cfgEn && !enQ;
    strobe.flagClr = flagClr;
    strobe.inc     = 1'b0;
    if (!cfgWr && enQ) begin
      unique case (modeQ)
        MODE_EVENT:   strobe.inc = evtEdge;
        MODE_TIMER:   strobe.inc = tick;
        MODE_CAPTURE: strobe.inc = inPulse && tick;
        default:      strobe.inc = 1'b0;
      endcase
    end
  end

  assign enOut = enQ;

endmodule

// File: rtl/tmr_dp.sv
module tmr_dp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strobe_t      strobe,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] cntOut,
  output logic             flagOut,
  output logic             ovfPulse
);

  logic [CNT_W-1:0] cntQ;
  logic             flagQ;

  assign ovfPulse = strobe.inc && (&cntQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       cntQ <= '0;
    else if (strobe.load || ovfPulse) cntQ <= preload;
    else if (strobe.inc)             cntQ <= cntQ + 1'b1;
  end

  // set dominates clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               flagQ <= 1'b0;
    else if (ovfPulse)       flagQ <= 1'b1;
    else if (strobe.flagClr) flagQ <= 1'b0;
  end

  assign cntOut  = cntQ;
  assign flagOut = flagQ;

endmodule

// File: rtl/dual_timer_pfd.sv
module dual_timer_pfd
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PSC_W = 3,
  localparam int NT   = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NT-1:0]             cfgWr,
  input  logic [NT-1:0][1:0]        cfgMode,
  input  logic [NT-1:0]             cfgEdge,
  input  logic [NT-1:0][PSC_W-1:0]  cfgPsc,
  input  logic [NT-1:0]             cfgEn,
  input  logic [NT-1:0][CNT_W-1:0]  preload,
  input  logic [NT-1:0]             extPin,
  input  logic [NT-1:0]             flagClr,
  input  logic                      pfdSel,
  output logic [NT-1:0][CNT_W-1:0]  count,
  output logic [NT-1:0]             ovfFlag,
  output logic [NT-1:0]             tmrEn,
  output logic                      pfdOut
);

  logic [NT-1:0] ovfPulse;

  for (genvar g = 0; g < NT; g++) begin : g_tmr
    tmr_strobe_t strobe;

    tmr_ctrl #(.PSC_W(PSC_W)) u_ctrl (
      .clk     (clk),
      .rstN    (rstN),
      .cfgWr   (cfgWr[g]),
      .cfgMode (cfgMode[g]),
      .cfgEdge (cfgEdge[g]),
      .cfgPsc  (cfgPsc[g]),
      .cfgEn   (cfgEn[g]),
      .pin     (extPin[g]),
      .flagClr (flagClr[g]),
      .strobe  (strobe),
      .enOut   (tmrEn[g])
    );

    tmr_dp #(.CNT_W(CNT_W)) u_dp (
      .clk      (clk),
      .rstN     (rstN),
      .strobe   (strobe),
      .preload  (preload[g]),
      .cntOut   (count[g]),
      .flagOut  (ovfFlag[g]),
      .ovfPulse (ovfPulse[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 pfdOut <= 1'b0;
    else if (ovfPulse[pfdSel]) pfdOut <= ~pfdOut;
  end

endmodule

// File: rtl/dual_timer_pfd_chk.sv
module dual_timer_pfd_chk #(
  parameter int CNT_W = 8,
  parameter int NT    = 2
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NT-1:0]            cfgWr,
  input logic [NT-1:0]            cfgEn,
  input logic [NT-1:0][CNT_W-1:0] preload,
  input logic [NT-1:0]            flagClr,
  input logic                     pfdSel,
  input logic [NT-1:0][CNT_W-1:0] count,
  input logic [NT-1:0]            ovfFlag,
  input logic [NT-1:0]            tmrEn,
  input logic                     pfdOut
);

  localparam logic [CNT_W-1:0] MAXC = {CNT_W{1'b1}};

  for (genvar g = 0; g < NT; g++) begin : g_chk
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!tmrEn[g] && !cfgWr[g]) |=> $stable(count[g]));

    p_load_on_enable_r11: assert property (@(posedge clk) disable iff (!rstN)
      (cfgWr[g] && cfgEn[g] && !tmrEn[g]) |=> (count[g] == $past(preload[g])));

    p_reload_on_ovf_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ovfFlag[g]) |-> ($past(count[g]) == MAXC && count[g] == $past(preload[g])));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
      (ovfFlag[g] && !flagClr[g]) |=> ovfFlag[g]);
  end

  p_pfd_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pfdOut) |-> (($past(pfdSel) ? $past(count[1]) : $past(count[0])) == MAXC));

endmodule

bind dual_timer_pfd dual_timer_pfd_chk #(.CNT_W(CNT_W), .NT(NT)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .cfgWr   (cfgWr),
  .cfgEn   (cfgEn),
  .preload (preload),
  .flagClr (flagClr),
  .pfdSel  (pfdSel),
  .count   (count),
  .ovfFlag (ovfFlag),
  .tmrEn   (tmrEn),
  .pfdOut  (pfdOut)
);

// File: tb/dual_timer_pfd_bench.sv
module dual_timer_pfd_bench;

  localparam logic [1:0] M_IDLE = 2'b00, M_EVT = 2'b01, M_TMR = 2'b10, M_CAP = 2'b11;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0]       cfgWr = '0;
  logic [1:0][1:0]  cfgMode = '0;
  logic [1:0]       cfgEdge = '0;
  logic [1:0][2:0]  cfgPsc = '0;
  logic [1:0]       cfgEn = '0;
  logic [1:0][7:0]  preload = '0;
  logic [1:0]       extPin = '0;
  logic [1:0]       flagClr = '0;
  logic             pfdSel = 1'b0;
  logic [1:0][7:0]  count;
  logic [1:0]       ovfFlag;
  logic [1:0]       tmrEn;
  logic             pfdOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_timer_pfd u_dual_timer_pfd (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMode(cfgMode), .cfgEdge(cfgEdge),
    .cfgPsc(cfgPsc), .cfgEn(cfgEn), .preload(preload), .extPin(extPin),
    .flagClr(flagClr), .pfdSel(pfdSel), .count(count), .ovfFlag(ovfFlag),
    .tmrEn(tmrEn), .pfdOut(pfdOut)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCfg(int t, logic [1:0] m, logic e, logic [2:0] p, logic en);
    cfgWr[t] = 1'b1; cfgMode[t] = m; cfgEdge[t] = e; cfgPsc[t] = p; cfgEn[t] = en;
    @(negedge clk);
    cfgWr[t] = 1'b0;
  endtask

  task automatic testReset();
    check("R1 count0", count[0], 0);
    check("R1 count1", count[1], 0);
    check("R1 flags", ovfFlag, 0);
    check("R1 enables", tmrEn, 0);
    check("R1 pfdOut", pfdOut, 0);
  endtask

  task automatic testIdle();
    preload[0] = 8'd5;
    writeCfg(0, M_IDLE, 0, 0, 1);
    check("R11 load on enable", count[0], 5);
    check("R2 enable set", tmrEn[0], 1);
    waitN(10);
    check("R2 idle mode holds", count[0], 5);
    writeCfg(0, M_IDLE, 0, 0, 0);
  endtask

  task automatic testTimer();
    preload[0] = 8'd0;
    writeCfg(0, M_TMR, 0, 3'd0, 1);
    waitN(10);
    check("R3 div1", count[0], 10);
    writeCfg(0, M_TMR, 0, 3'd0, 0);
    waitN(5);
    check("R2 disabled holds", count[0], 10);
    writeCfg(0, M_TMR, 0, 3'd3, 1);
    waitN(20);
    check("R3 div8", count[0], 2);
    writeCfg(0, M_TMR, 0, 3'd0, 0);
    writeCfg(0, M_TMR, 0, 3'd7, 1);
    waitN(127);
    check("R3 div128 before first tick", count[0], 0);
    waitN(1);
    check("R3 div128 first tick", count[0], 1);
    waitN(172);
    check("R3 div128 after 300", count[0], 2);
    writeCfg(0, M_TMR, 0, 3'd0, 0);
  endtask

  task automatic testEvent();
    preload[0] = 8'd0;
    writeCfg(0, M_EVT, 0, 0, 1);
    extPin[0] = 1'b1;
    waitN(2);
    check("R4 latency not yet", count[0], 0);
    waitN(1);
    check("R4 rising counted", count[0], 1);
    waitN(3);
    extPin[0] = 1'b0;
    waitN(4);
    check("R4 falling ignored", count[0], 1);
    repeat (2) begin
      extPin[0] = 1'b1; waitN(3);
      extPin[0] = 1'b0; waitN(3);
    end
    check("R4 three rising", count[0], 3);
    writeCfg(0, M_EVT, 0, 0, 0);
    writeCfg(0, M_EVT, 1, 0, 1);
    extPin[0] = 1'b1; waitN(4);
    check("R4 edge1 rising ignored", count[0], 0);
    extPin[0] = 1'b0; waitN(4);
    check("R4 edge1 falling counted", count[0], 1);
    writeCfg(0, M_EVT, 1, 0, 0);
  endtask

  task automatic testOverflow();
    pfdSel = 1'b0;
    preload[0] = 8'd250;
    writeCfg(0, M_TMR, 0, 0, 1);
    waitN(5);
    check("R5 at top", count[0], 255);
    check("R5 flag not yet", ovfFlag[0], 0);
    waitN(1);
    check("R5 reload", count[0], 250);
    check("R5 flag set", ovfFlag[0], 1);
    check("R10 pfd toggled", pfdOut, 1);
    waitN(6);
    check("R10 pfd second toggle", pfdOut, 0);
    writeCfg(0, M_TMR, 0, 0, 0);
  endtask

  task automatic testFlagClear();
    flagClr[0] = 1'b1; waitN(1); flagClr[0] = 1'b0;
    check("R6 quiet clear", ovfFlag[0], 0);
    preload[0] = 8'd250;
    writeCfg(0, M_TMR, 0, 0, 1);
    waitN(5);
    check("R6 flag clear before", ovfFlag[0], 0);
    flagClr[0] = 1'b1; waitN(1); flagClr[0] = 1'b0;
    check("R6 set wins over clear", ovfFlag[0], 1);
    check("R5 reload at coincidence", count[0], 250);
    writeCfg(0, M_TMR, 0, 0, 0);
    flagClr[0] = 1'b1; waitN(1); flagClr[0] = 1'b0;
    check("R6 clear after", ovfFlag[0], 0);
    check("R10 pfd after third overflow", pfdOut, 1);
  endtask

  task automatic testCaptureFall();
    extPin[1] = 1'b1; waitN(4);
    preload[1] = 8'd0;
    writeCfg(1, M_CAP, 0, 0, 1);
    waitN(3);
    check("R7 waits for start", count[1], 0);
    extPin[1] = 1'b0; waitN(7);
    extPin[1] = 1'b1; waitN(5);
    check("R7 width 7", count[1], 7);
    check("R7 auto disable", tmrEn[1], 0);
    extPin[1] = 1'b0; waitN(3);
    extPin[1] = 1'b1; waitN(4);
    check("R7 halted after stop", count[1], 7);
  endtask

  task automatic testCaptureRise();
    extPin[1] = 1'b0; waitN(4);
    preload[1] = 8'd0;
    writeCfg(1, M_CAP, 1, 0, 1);
    check("R8 enabled", tmrEn[1], 1);
    extPin[1] = 1'b1; waitN(9);
    extPin[1] = 1'b0; waitN(5);
    check("R8 width 9", count[1], 9);
    check("R8 auto disable", tmrEn[1], 0);
  endtask

  task automatic testCaptureOvf();
    pfdSel = 1'b1;
    preload[1] = 8'd250;
    writeCfg(1, M_CAP, 1, 0, 1);
    extPin[1] = 1'b1; waitN(10);
    extPin[1] = 1'b0; waitN(5);
    check("R9 count after wrap", count[1], 254);
    check("R9 flag set", ovfFlag[1], 1);
    check("R9 auto disable", tmrEn[1], 0);
    check("R10 pfd from timer1", pfdOut, 0);
  endtask

  task automatic testSelIgnore();
    pfdSel = 1'b1;
    preload[0] = 8'd250;
    writeCfg(0, M_TMR, 0, 0, 1);
    waitN(20);
    check("R10 timer0 overflow ignored", pfdOut, 0);
    check("R5 timer0 did overflow", ovfFlag[0], 1);
    writeCfg(0, M_TMR, 0, 0, 0);
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    testReset();
    testIdle();
    testTimer();
    testEvent();
    testOverflow();
    testFlagClear();
    testCaptureFall();
    testCaptureRise();
    testCaptureOvf();
    testSelIgnore();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule